// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block is one router of a two-dimensional mesh fabric. It has five ports: one local port for the attached core and one port for each compass neighbour. Traffic moves as worms. A worm is a head flit that carries the destination column and row, then zero or more body flits, then a tail flit. A one-flit message is a single flit marked as both head and tail. Every input and every output uses a valid/ready handshake. Each input stores exactly one flit.

A head flit is routed by dimension order. It first travels east or west until its column matches the router's own column. It then travels north or south until its row matches. When both match, it leaves on the local port. This gives one path between any two nodes, and that path has the minimum hop count. The head claims the output that its route selects. That output stays locked to the head's input until the worm's tail is accepted downstream, and only then can another worm take it. If the output is already locked, the head waits in its input register, and the rest of its worm backs up behind it. When several heads want the same free output in one cycle, a round-robin arbiter picks one of them.

Top module: `wmr_router`

## Requirements
- R1: After reset every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: Port indices are 0 local, 1 north, 2 south, 3 east, 4 west. Each flit is laid out as {kind[1:0], dst_x[X_W], dst_y[Y_W], payload[PAY_W]}, with the most significant bits first. A head leaves on east if dst_x > MY_X and on west if dst_x < MY_X. If dst_x equals MY_X, it leaves on north if dst_y > MY_Y, on south if dst_y < MY_Y, and on local otherwise.
- R3: An input holds one flit. While that flit cannot leave, the input accepts exactly one flit and then holds `in_ready` low.
- R4: While an output shows a flit with `out_ready` low, the next cycle still shows the same flit with `out_valid` high.
- R5: The flit kinds are 2'b10 head, 2'b00 body, 2'b01 tail and 2'b11 single. After a head (2'b10) is accepted on an output, that output carries only body or tail flits from the same input until the tail has been accepted. A competing head waits in its input during this time.
- R6: A lock is freed in the cycle its tail is accepted. A waiting head can leave on that output in the very next cycle, so there is no idle cycle between worms.
- R7: When several heads first request the same free output together, the grant goes to the first requester at or after the index following the last input granted that output.
- R8: A single flit (kind 2'b11) takes no lasting lock. Another head can use the same output in the next cycle.
- R9: Every flit accepted at an input is delivered exactly once, and the flits of a worm leave in the order they were sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Flit offered on each input port |
| in_flit | input | 5*FW | Input flits, port p in bits [p*FW +: FW] |
| in_ready | output | 5 | Input register can take a flit this cycle |
| out_valid | output | 5 | Flit presented on each output port |
| out_flit | output | 5*FW | Output flits, port p in bits [p*FW +: FW] |
| out_ready | input | 5 | Downstream takes the flit this cycle |

## Verification
The assertions rely on well-formed worms from each input: every body or tail is preceded by a head on that input, and an input never starts a new head before its previous worm's tail. The assertions also rely on senders holding a flit steady until it is taken. The bench's drivers build every worm from one head, body flits and one tail, or as one single flit. They hold each flit until `in_ready` is seen, and they draw destinations only inside the router's coordinate range. Downstream readiness is driven freely, blocked, open or random, because the block places no rule on it.

// File: rtl/wmr_pkg.sv
package wmr_pkg;
  localparam int NPORT = 5;
  localparam int PW    = 3;

  localparam logic [PW-1:0] P_LOCAL = 3'd0;
  localparam logic [PW-1:0] P_NORTH = 3'd1;
  localparam logic [PW-1:0] P_SOUTH = 3'd2;
  localparam logic [PW-1:0] P_EAST  = 3'd3;
  localparam logic [PW-1:0] P_WEST  = 3'd4;

  // flit kind: bit1 marks a head, bit0 marks the end of a worm
  localparam logic [1:0] K_BODY = 2'b00;
  localparam logic [1:0] K_TAIL = 2'b01;
  localparam logic [1:0] K_HEAD = 2'b10;
  localparam logic [1:0] K_SOLO = 2'b11;
endpackage

// File: rtl/wmr_xy_route.sv
module wmr_xy_route
  import wmr_pkg::*;
#(
  parameter int X_W  = 3,
  parameter int Y_W  = 3,
  parameter int MY_X = 2,
  parameter int MY_Y = 2
) (
  input  logic [X_W-1:0] dst_x,
  input  logic [Y_W-1:0] dst_y,
  output logic [PW-1:0]  dir
);
  localparam logic [X_W-1:0] HX = X_W'(MY_X);
  localparam logic [Y_W-1:0] HY = Y_W'(MY_Y);

  // column first, then row, then deliver
  always_comb begin
    if (dst_x > HX)      dir = P_EAST;
    else if (dst_x < HX) dir = P_WEST;
    else if (dst_y > HY) dir = P_NORTH;
    else if (dst_y < HY) dir = P_SOUTH;
    else                 dir = P_LOCAL;
  end
endmodule

// File: rtl/wmr_rr_arb.sv
module wmr_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr;

  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      for (int i = 0; i < N; i++) begin
        if (gnt[i]) ptr <= (i == N - 1) ? '0 : IW'(i + 1);
      end
    end
  end
endmodule

// File: rtl/wmr_in_slot.sv
module wmr_in_slot #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [FW-1:0] in_flit,
  output logic          in_ready,
  input  logic          pop,
  output logic          full,
  output logic [FW-1:0] flit
);
  assign in_ready = !full || pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (in_valid && in_ready) begin
      full <= 1'b1;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) flit <= in_flit;
  end
endmodule

// File: rtl/wmr_router.sv
module wmr_router
  import wmr_pkg::*;
#(
  parameter int X_W   = 3,
  parameter int Y_W   = 3,
  parameter int PAY_W = 8,
  parameter int MY_X  = 2,
  parameter int MY_Y  = 2,
  localparam int FW   = 2 + X_W + Y_W + PAY_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORT-1:0]    in_valid,
  input  logic [NPORT*FW-1:0] in_flit,
  output logic [NPORT-1:0]    in_ready,
  output logic [NPORT-1:0]    out_valid,
  output logic [NPORT*FW-1:0] out_flit,
  input  logic [NPORT-1:0]    out_ready
);
  logic [FW-1:0]    slot_flit [NPORT];
  logic [NPORT-1:0] slot_full;
  logic [NPORT-1:0] pop;
  logic [PW-1:0]    dir       [NPORT];
  logic [NPORT-1:0] req       [NPORT];
  logic [NPORT-1:0] gnt       [NPORT];
  logic [NPORT-1:0] lock_v;
  logic [PW-1:0]    lock_own  [NPORT];
  logic [NPORT-1:0] conn_v;
  logic [PW-1:0]    conn_src  [NPORT];
  logic [FW-1:0]    conn_flit [NPORT];
  logic [NPORT-1:0] conn_full;
  logic [NPORT-1:0] accept;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    wmr_in_slot #(.FW(FW)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid[i]),
      .in_flit  (in_flit[i*FW +: FW]),
      .in_ready (in_ready[i]),
      .pop      (pop[i]),
      .full     (slot_full[i]),
      .flit     (slot_flit[i])
    );

    wmr_xy_route #(.X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
      .dst_x (slot_flit[i][FW-3 -: X_W]),
      .dst_y (slot_flit[i][PAY_W + Y_W - 1 -: Y_W]),
      .dir   (dir[i])
    );
  end

  // a head may ask only for a free output
  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        req[o][i] = slot_full[i] && slot_flit[i][FW-1] &&
                    (dir[i] == PW'(o)) && !lock_v[o];
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    wmr_rr_arb #(.N(NPORT)) u_arb (
      .clk (clk),
      .rst (rst),
      .req (req[o]),
      .adv (!lock_v[o]),
      .gnt (gnt[o])
    );
  end

  // crossbar select: lock owner, else this cycle's grant
  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      conn_v[o]    = lock_v[o];
      conn_src[o]  = lock_own[o];
      if (!lock_v[o]) begin
        for (int i = 0; i < NPORT; i++) begin
          if (gnt[o][i]) begin
            conn_v[o]   = 1'b1;
            conn_src[o] = PW'(i);
          end
        end
      end
      conn_flit[o] = '0;
      conn_full[o] = 1'b0;
      for (int i = 0; i < NPORT; i++) begin
        if (conn_src[o] == PW'(i)) begin
          conn_flit[o] = slot_flit[i];
          conn_full[o] = slot_full[i];
        end
      end
      out_valid[o]            = conn_v[o] && conn_full[o];
      out_flit[o*FW +: FW]    = conn_flit[o];
      accept[o]               = out_valid[o] && out_ready[o];
    end
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        if (accept[o] && conn_src[o] == PW'(i)) pop[i] = 1'b1;
      end
    end
  end

  // lock table: claimed on grant, dropped when the worm end is taken
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_v <= '0;
      for (int o = 0; o < NPORT; o++) lock_own[o] <= '0;
    end else begin
      for (int o = 0; o < NPORT; o++) begin
        if (!lock_v[o] && conn_v[o]) begin
          lock_v[o]   <= !(accept[o] && conn_flit[o][FW-2]);
          lock_own[o] <= conn_src[o];
        end else if (lock_v[o] && accept[o] && conn_flit[o][FW-2]) begin
          lock_v[o] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/wmr_router_chk.sv
module wmr_router_chk
  import wmr_pkg::*;
#(
  parameter int X_W   = 3,
  parameter int Y_W   = 3,
  parameter int PAY_W = 8,
  parameter int MY_X  = 2,
  parameter int MY_Y  = 2,
  localparam int FW   = 2 + X_W + Y_W + PAY_W
) (
  input logic                clk,
  input logic                rst,
  input logic [NPORT-1:0]    in_valid,
  input logic [NPORT*FW-1:0] in_flit,
  input logic [NPORT-1:0]    in_ready,
  input logic [NPORT-1:0]    out_valid,
  input logic [NPORT*FW-1:0] out_flit,
  input logic [NPORT-1:0]    out_ready
);
  for (genvar o = 0; o < NPORT; o++) begin : g_port
    logic [1:0]     kind;
    logic [X_W-1:0] dx;
    logic [Y_W-1:0] dy;
    logic           open_w;

    assign kind = out_flit[o*FW + FW - 1 -: 2];
    assign dx   = out_flit[o*FW + FW - 3 -: X_W];
    assign dy   = out_flit[o*FW + PAY_W + Y_W - 1 -: Y_W];

    always_ff @(posedge clk) begin
      if (rst) open_w <= 1'b0;
      else if (out_valid[o] && out_ready[o]) begin
        if (kind == K_HEAD) open_w <= 1'b1;
        else if (kind[0])   open_w <= 1'b0;
      end
    end

    // R4
    hold_flit_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_flit[o*FW +: FW]));

    // R5
    no_head_in_worm_chk: assert property (@(posedge clk) disable iff (rst)
      open_w && out_valid[o] |-> !kind[1]);

    // R5
    worm_starts_head_chk: assert property (@(posedge clk) disable iff (rst)
      !open_w && out_valid[o] |-> kind[1]);

    if (o == 3) begin : g_e
      // R2
      east_route_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid[o] && kind[1] |-> dx > X_W'(MY_X));
    end else if (o == 4) begin : g_w
      // R2
      west_route_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid[o] && kind[1] |-> dx < X_W'(MY_X));
    end else if (o == 0) begin : g_l
      // R2
      local_route_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid[o] && kind[1] |-> dx == X_W'(MY_X) && dy == Y_W'(MY_Y));
    end else begin : g_ns
      // R2
      x_before_y_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid[o] && kind[1] |-> dx == X_W'(MY_X) && dy != Y_W'(MY_Y));
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> out_valid == '0 && in_ready == '1);
endmodule

bind wmr_router wmr_router_chk #(
  .X_W(X_W), .Y_W(Y_W), .PAY_W(PAY_W), .MY_X(MY_X), .MY_Y(MY_Y)
) u_chk (.*);

// File: tb/wmr_router_bench.sv
`timescale 1ns/1ps
module wmr_router_bench;
  import wmr_pkg::*;
  localparam int X_W = 3, Y_W = 3, PAY_W = 8, MY_X = 2, MY_Y = 2;
  localparam int FW = 2 + X_W + Y_W + PAY_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic                iv  [NPORT];
  logic [FW-1:0]       ifl [NPORT];
  logic [NPORT-1:0]    in_valid, in_ready, out_valid, out_ready;
  logic [NPORT*FW-1:0] in_flit, out_flit;

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      in_valid[i]          = iv[i];
      in_flit[i*FW +: FW]  = ifl[i];
    end
  end

  wmr_router #(.X_W(X_W), .Y_W(Y_W), .PAY_W(PAY_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_wmr_router (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
    .out_valid(out_valid), .out_flit(out_flit), .out_ready(out_ready)
  );

  int checks = 0, fails = 0, sent = 0, recv = 0, cyc = 0, rdy_mode = 0;
  bit done = 0;
  int head_log[$];
  int time_log[$];
  int log_port = 3;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_dir(input int x, input int y);
    if (x > MY_X) return 3;
    if (x < MY_X) return 4;
    if (y > MY_Y) return 1;
    if (y < MY_Y) return 2;
    return 0;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int o = 0; o < NPORT; o++) begin
      case (rdy_mode)
        0: out_ready[o] <= 1'b0;
        1: out_ready[o] <= 1'b1;
        default: out_ready[o] <= ($urandom % 4) != 0;
      endcase
    end
  end

  task automatic send_worm(input int i, input int dx, input int dy, input int len);
    for (int k = 0; k < len; k++) begin
      logic [1:0] kd;
      bit fire;
      kd = (len == 1) ? K_SOLO : (k == 0) ? K_HEAD : (k == len - 1) ? K_TAIL : K_BODY;
      @(negedge clk);
      iv[i]  = 1'b1;
      ifl[i] = {kd, X_W'(dx), Y_W'(dy), 3'(i), 5'(k)};
      fire = 0;
      while (!fire) begin
        #1;
        fire = in_ready[i];
        if (!fire) @(negedge clk);
      end
      sent++;
      @(posedge clk);
    end
    @(negedge clk);
    iv[i] = 1'b0;
  endtask

  task automatic rand_stream(input int i);
    for (int w = 0; w < 20; w++) begin
      send_worm(i, int'($urandom % 5), int'($urandom % 5), 1 + int'($urandom % 4));
      repeat (int'($urandom % 3)) @(negedge clk);
    end
  endtask

  // output monitor, sampling just before the capturing edge
  bit            open_w [NPORT];
  int            cur_src[NPORT];
  int            nxt_seq[NPORT];
  bit            held_v [NPORT];
  logic [FW-1:0] held_f [NPORT];
  initial begin
    for (int o = 0; o < NPORT; o++) begin
      open_w[o] = 0; held_v[o] = 0; cur_src[o] = 0; nxt_seq[o] = 0;
    end
    forever begin
      @(negedge clk); #2;
      if (!rst) begin
        for (int o = 0; o < NPORT; o++) begin
          logic [FW-1:0] f;
          int kd, x, y, src, seq;
          f = out_flit[o*FW +: FW];
          kd = int'(f[FW-1 -: 2]); x = int'(f[FW-3 -: X_W]);
          y = int'(f[PAY_W+Y_W-1 -: Y_W]); src = int'(f[7:5]); seq = int'(f[4:0]);
          if (held_v[o]) chk(out_valid[o] && f == held_f[o], "R4 held flit", longint'(f), longint'(held_f[o]));
          held_v[o] = out_valid[o] && !out_ready[o];
          held_f[o] = f;
          if (out_valid[o] && out_ready[o]) begin
            recv++;
            if (o == log_port) time_log.push_back(cyc);
            if (kd[1]) begin
              if (o == log_port) head_log.push_back(src);
              chk(exp_dir(x, y) == o, "R2 route", o, exp_dir(x, y));
              chk(!open_w[o], "R5 head inside worm", open_w[o], 0);
              chk(seq == 0, "R9 head sequence", seq, 0);
              open_w[o] = (kd == 2);
              cur_src[o] = src; nxt_seq[o] = 1;
            end else begin
              chk(open_w[o] && src == cur_src[o], "R5 worm source", src, cur_src[o]);
              chk(seq == nxt_seq[o], "R9 flit order", seq, nxt_seq[o]);
              nxt_seq[o]++;
              if (kd == 1) open_w[o] = 0;
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NPORT; i++) begin iv[i] = 0; ifl[i] = '0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1
    chk(out_valid == '0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == '1, "R1 in_ready after reset", in_ready, 31);

    // R3 and R5: east blocked, west worm holds the lock, local head waits
    rdy_mode = 0;
    fork send_worm(4, 4, 2, 3); join_none
    repeat (2) @(negedge clk);
    fork send_worm(0, 3, 0, 2); join_none
    repeat (6) @(negedge clk);
    #1;
    chk(in_ready[4] == 0, "R3 one flit held, ready low", in_ready[4], 0);
    chk(in_ready[0] == 0, "R5 waiting head stalls input", in_ready[0], 0);
    chk(out_valid[3] == 1, "R3 blocked head shown", out_valid[3], 1);
    chk(out_flit[3*FW + 7 -: 3] == 3'd4, "R5 lock owner on east", out_flit[3*FW + 7 -: 3], 4);
    rdy_mode = 1;
    repeat (20) @(negedge clk);

    // R7 and R6: solo from south steers the pointer, then north and west race
    fork send_worm(2, 4, 2, 1); join_none
    repeat (8) @(negedge clk);
    head_log.delete(); time_log.delete();
    fork send_worm(1, 3, 1, 2); send_worm(4, 3, 4, 2); join_none
    repeat (15) @(negedge clk);
    chk(head_log.size() == 2 && head_log[0] == 4, "R7 round-robin first winner",
        head_log.size() > 0 ? head_log[0] : -1, 4);
    chk(time_log.size() == 4 && time_log[3] - time_log[0] == 3, "R6 back-to-back worms",
        time_log.size() == 4 ? time_log[3] - time_log[0] : -1, 3);

    // R8: two single flits to local leave on consecutive cycles
    log_port = 0;
    head_log.delete(); time_log.delete();
    fork send_worm(0, 2, 2, 1); send_worm(2, 2, 2, 1); join_none
    repeat (10) @(negedge clk);
    chk(time_log.size() == 2 && time_log[1] - time_log[0] == 1, "R8 single flit no lock",
        time_log.size() == 2 ? time_log[1] - time_log[0] : -1, 1);

    // random traffic with random downstream readiness
    log_port = 7;
    rdy_mode = 2;
    for (int i = 0; i < NPORT; i++) begin
      automatic int ii = i;
      fork rand_stream(ii); join_none
    end
    wait fork;
    rdy_mode = 1;
    repeat (30) @(negedge clk);
    chk(recv == sent, "R9 all flits delivered", recv, sent);
    chk(out_valid == '0, "R9 router drained", out_valid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule